// File: doc/BRIEF.md
# Dual-Action Timer Channel

This block is one channel of a timer. It watches two free-running 24-bit time bases and holds two match stages, A and B, each with its own match value and capture register. When an armed stage sees its selected time base reach its match value, the stage fires. It latches the other time base into its capture register and raises its event flag. It can also drive the output pin high, low or to the opposite level. Either stage can instead fire on a qualified edge of the input pin, which captures the stage's own time base.

In single-action mode the two stages run independently. In double-action mode stage B waits until stage A has fired, so one channel can run a two-step sequence such as a pulse with a programmed start and end. Service is simple. The host reads the flags and clears them with a write-one-to-clear, or it rewrites a match value, which clears that stage's flag and arms the stage again.

Top module: `dual_match_chan`

## Requirements
- R1: While reset is asserted every host-readable register reads 0, pin_out and pin_out_state are 0, evt_flag is 0 and svc_req is 0.
- R2: In reach mode (equal-only bit clear), an armed stage fires on the first clock edge where (base - match) mod 2^24 is below 2^23. A match value written up to 2^23-1 counts behind the base fires at once.
- R3: In equal-only mode (ctrl bit 1 for A, bit 2 for B), an armed stage fires only when its base equals the match value exactly.
- R4: When a stage fires on a match, it captures the time base it does not compare against, sets its flag and disarms. Each stage's base select is ctrl bit 7 for A and bit 8 for B (0 compares time_a, 1 compares time_b).
- R5: A match firing applies that stage's pin action to pin_out: 0 none, 1 drive high, 2 drive low, 3 toggle. The action field is ctrl[4:3] for A and ctrl[6:5] for B. When both stages fire in the same cycle, A's action is applied first and B's second.
- R6: In single-action mode (ctrl bit 0 clear) the two stages arm and fire independently of each other.
- R7: In double-action mode (ctrl bit 0 set), writing match B only loads the value. B becomes armed in the cycle after A fires, and writing match A disarms B.
- R8: A host write to the match register (address 1 for A, 2 for B) clears that stage's flag. In single-action mode it also arms that stage, and this write takes precedence over a firing in the same cycle. Flags otherwise stay set until a write of 1 to the matching status bit (address 5, bit 0 for A, bit 1 for B).
- R9: With an input edge selected in ctrl[10:9] (0 off, 1 rising, 2 falling, 3 both), a qualifying edge makes every armed stage capture its own compared base, set its flag and disarm, without changing pin_out. The stage fires two edges after the pin changes. A match in the same cycle wins.
- R10: Reading address 5 returns flag A in bit 0, flag B in bit 1, armed A in bit 2, armed B in bit 3, the input level in bit 4 and the output level in bit 5. The input level and pin_in_state follow pin_in one clock later.
- R11: svc_req is high exactly when at least one event flag is set. Captures are read at address 3 (A) and 4 (B), and ctrl at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| time_a | input | 24 | First time base |
| time_b | input | 24 | Second time base |
| pin_in | input | 1 | Channel input pin, synchronous to clk |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 24 | Host write data |
| host_rdata | output | 24 | Host read data for host_addr (combinational) |
| pin_out | output | 1 | Channel output pin |
| pin_in_state | output | 1 | Registered input level |
| pin_out_state | output | 1 | Current output level |
| evt_flag | output | 2 | Event flags, bit 0 stage A, bit 1 stage B |
| svc_req | output | 1 | Service request |

## Verification
The checks assume that pin_in is already synchronous to clk. They also assume that in reach mode the compared base moves less than half its range between arming and firing, because the modular test cannot tell a value just reached from one almost a full wrap away. The bench sets both time bases to chosen values at the falling edge rather than counting them, which puts every compare difference exactly where intended. This includes the values around 2^23 and 2^24. The bench changes the configuration only while no stage that matters is armed, so no action changes meaning partway through a sequence.

// File: rtl/dual_match_pkg.sv
package dual_match_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_HIGH   = 2'd1,
        ACT_LOW    = 2'd2,
        ACT_TOGGLE = 2'd3
    } pin_act_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_sel_e;

    // packed MSB first: [10:9] edge, [8] base B, [7] base A,
    // [6:5] act B, [4:3] act A, [2] eq B, [1] eq A, [0] double
    typedef struct packed {
        edge_sel_e edge_sel;
        logic      base_b;
        logic      base_a;
        pin_act_e  act_b;
        pin_act_e  act_a;
        logic      eq_b;
        logic      eq_a;
        logic      dbl;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [2:0] ADDR_CTRL    = 3'd0;
    localparam logic [2:0] ADDR_MATCH_A = 3'd1;
    localparam logic [2:0] ADDR_MATCH_B = 3'd2;
    localparam logic [2:0] ADDR_CAP_A   = 3'd3;
    localparam logic [2:0] ADDR_CAP_B   = 3'd4;
    localparam logic [2:0] ADDR_STAT    = 3'd5;

    function automatic logic apply_act(input logic cur, input pin_act_e act);
        case (act)
            ACT_HIGH:   return 1'b1;
            ACT_LOW:    return 1'b0;
            ACT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/dual_match_cmp.sv
module dual_match_cmp #(
    parameter int TB_W = 24
) (
    input  logic [TB_W-1:0] base,
    input  logic [TB_W-1:0] match_val,
    input  logic            eq_only,
    output logic            hit
);
    localparam logic [TB_W-1:0] HALF = {1'b1, {(TB_W-1){1'b0}}};

    logic [TB_W-1:0] diff;

    always_comb begin
        diff = base - match_val;
        if (eq_only) hit = (base == match_val);
        else         hit = (diff < HALF);
    end

    always_comb begin
        assert (!(eq_only && hit) || (diff == '0))
            else $error("a_r3_eq_exact");
    end
endmodule

// File: rtl/dual_match_sync.sv
module dual_match_sync
    import dual_match_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_in,
    input  edge_sel_e edge_sel,
    output logic      pin_lvl,
    output logic      edge_hit
);
    typedef struct packed {
        logic cur;
        logic prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.cur  = pin_in;
        sync_d.prev = sync_q.cur;
        case (edge_sel)
            EDGE_RISE: edge_hit =  sync_q.cur & ~sync_q.prev;
            EDGE_FALL: edge_hit = ~sync_q.cur &  sync_q.prev;
            EDGE_BOTH: edge_hit =  sync_q.cur ^  sync_q.prev;
            default:   edge_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign pin_lvl = sync_q.cur;

    // R10: the level seen by the host is pin_in from the previous edge
    a_r10_level_lag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pin_lvl == $past(pin_in)));
endmodule

// File: rtl/dual_match_drive.sv
module dual_match_drive
    import dual_match_pkg::*;
(
    input  logic     pin_cur,
    input  logic [1:0] fire,
    input  pin_act_e act_a,
    input  pin_act_e act_b,
    output logic     pin_nxt
);
    logic after_a;

    always_comb begin
        after_a = fire[0] ? apply_act(pin_cur, act_a) : pin_cur;
        pin_nxt = fire[1] ? apply_act(after_a, act_b) : after_a;
    end

    always_comb begin
        assert ((fire != 2'b00) || (pin_nxt == pin_cur))
            else $error("a_r5_idle_hold");
    end
endmodule

// File: rtl/dual_match_chan.sv
module dual_match_chan
    import dual_match_pkg::*;
#(
    parameter int TB_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TB_W-1:0] time_a,
    input  logic [TB_W-1:0] time_b,
    input  logic            pin_in,
    input  logic            host_we,
    input  logic [2:0]      host_addr,
    input  logic [TB_W-1:0] host_wdata,
    output logic [TB_W-1:0] host_rdata,
    output logic            pin_out,
    output logic            pin_in_state,
    output logic            pin_out_state,
    output logic [1:0]      evt_flag,
    output logic            svc_req
);
    localparam int N_STG  = 2;
    localparam int STAT_W = 6;

    typedef struct packed {
        ctrl_t                       ctrl;
        logic [N_STG-1:0][TB_W-1:0]  match;
        logic [N_STG-1:0][TB_W-1:0]  cap;
        logic [N_STG-1:0]            armed;
        logic [N_STG-1:0]            flag;
        logic                        pin;
    } chan_t;

    chan_t chan_d, chan_q;

    logic [TB_W-1:0]  cmp_base   [N_STG];
    logic [TB_W-1:0]  cap_other  [N_STG];
    logic [N_STG-1:0] hit;
    logic [N_STG-1:0] wr_match;
    logic [N_STG-1:0] evt_match;
    logic [N_STG-1:0] evt_edge;
    logic [N_STG-1:0] evt_any;
    logic [N_STG-1:0] base_pick;
    logic [N_STG-1:0] eq_pick;
    logic             wr_ctrl;
    logic             wr_stat;
    logic             edge_hit;
    logic             pin_lvl;
    logic             pin_nxt;
    logic [STAT_W-1:0] stat_word;

    assign wr_ctrl   = host_we && (host_addr == ADDR_CTRL);
    assign wr_stat   = host_we && (host_addr == ADDR_STAT);
    assign base_pick = {chan_q.ctrl.base_b, chan_q.ctrl.base_a};
    assign eq_pick   = {chan_q.ctrl.eq_b, chan_q.ctrl.eq_a};

    dual_match_sync i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .edge_sel (chan_q.ctrl.edge_sel),
        .pin_lvl  (pin_lvl),
        .edge_hit (edge_hit)
    );

    for (genvar g = 0; g < N_STG; g++) begin : g_stage
        assign cmp_base[g]  = base_pick[g] ? time_b : time_a;
        assign cap_other[g] = base_pick[g] ? time_a : time_b;
        assign wr_match[g]  = host_we && (host_addr == ADDR_MATCH_A + 3'(g));

        dual_match_cmp #(.TB_W(TB_W)) i_cmp (
            .base      (cmp_base[g]),
            .match_val (chan_q.match[g]),
            .eq_only   (eq_pick[g]),
            .hit       (hit[g])
        );

        assign evt_match[g] = chan_q.armed[g] & hit[g] & ~wr_match[g];
        assign evt_edge[g]  = chan_q.armed[g] & edge_hit & ~hit[g] & ~wr_match[g];
        assign evt_any[g]   = evt_match[g] | evt_edge[g];
    end

    dual_match_drive i_drive (
        .pin_cur (chan_q.pin),
        .fire    (evt_match),
        .act_a   (chan_q.ctrl.act_a),
        .act_b   (chan_q.ctrl.act_b),
        .pin_nxt (pin_nxt)
    );

    always_comb begin
        chan_d = chan_q;

        if (wr_ctrl) chan_d.ctrl = ctrl_t'(host_wdata[CTRL_W-1:0]);
        if (wr_stat) chan_d.flag = chan_q.flag & ~host_wdata[1:0];

        for (int i = 0; i < N_STG; i++) begin
            if (evt_any[i]) begin
                chan_d.armed[i] = 1'b0;
                chan_d.flag[i]  = 1'b1;
                chan_d.cap[i]   = evt_match[i] ? cap_other[i] : cmp_base[i];
            end
        end

        if (chan_q.ctrl.dbl && evt_any[0]) chan_d.armed[1] = 1'b1;

        if (wr_match[0]) begin
            chan_d.match[0] = host_wdata;
            chan_d.flag[0]  = 1'b0;
            chan_d.armed[0] = 1'b1;
            if (chan_q.ctrl.dbl) chan_d.armed[1] = 1'b0;
        end
        if (wr_match[1]) begin
            chan_d.match[1] = host_wdata;
            chan_d.flag[1]  = 1'b0;
            if (!chan_q.ctrl.dbl) chan_d.armed[1] = 1'b1;
        end

        chan_d.pin = pin_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chan_q <= '0;
        else        chan_q <= chan_d;
    end

    assign stat_word = {chan_q.pin, pin_lvl, chan_q.armed, chan_q.flag};

    always_comb begin
        case (host_addr)
            ADDR_CTRL:    host_rdata = TB_W'(chan_q.ctrl);
            ADDR_MATCH_A: host_rdata = chan_q.match[0];
            ADDR_MATCH_B: host_rdata = chan_q.match[1];
            ADDR_CAP_A:   host_rdata = chan_q.cap[0];
            ADDR_CAP_B:   host_rdata = chan_q.cap[1];
            ADDR_STAT:    host_rdata = TB_W'(stat_word);
            default:      host_rdata = '0;
        endcase
    end

    assign pin_out       = chan_q.pin;
    assign pin_out_state = chan_q.pin;
    assign pin_in_state  = pin_lvl;
    assign evt_flag      = chan_q.flag;
    assign svc_req       = |chan_q.flag;

    // R8: a flag holds until cleared by status write or match rewrite
    a_r8_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_q.flag[0] && !(wr_stat && host_wdata[0]) && !wr_match[0])
        |=> chan_q.flag[0]);

    // R4: a comparator hit on an armed stage disarms it and raises its flag
    a_r4_fire_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_q.armed[0] && hit[0] && !wr_match[0])
        |=> (!chan_q.armed[0] && chan_q.flag[0]));

    // R7: in double mode B only becomes armed right after A fires
    a_r7_b_after_a: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(chan_q.armed[1]) && $past(chan_q.ctrl.dbl)) |-> $past(evt_any[0]));

    // R5: no match firing, no pin change
    a_r5_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_match == 2'b00) |=> $stable(pin_out));

    // R4: capture A changes only on an A event
    a_r4_cap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_any[0] |=> $stable(chan_q.cap[0]));
endmodule

// File: tb/test_dual_match_chan.sv
`timescale 1ns/1ps
module test_dual_match_chan;
    localparam int W = 24;
    localparam logic [W-1:0] MASK = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] time_a = '0, time_b = '0;
    logic         pin_in = 1'b0;
    logic         host_we = 1'b0;
    logic [2:0]   host_addr = '0;
    logic [W-1:0] host_wdata = '0;
    logic [W-1:0] host_rdata;
    logic         pin_out, pin_in_state, pin_out_state, svc_req;
    logic [1:0]   evt_flag;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dual_match_chan #(.TB_W(W)) i_dual_match_chan (
        .clk(clk), .rst_n(rst_n), .time_a(time_a), .time_b(time_b),
        .pin_in(pin_in), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .pin_out(pin_out),
        .pin_in_state(pin_in_state), .pin_out_state(pin_out_state),
        .evt_flag(evt_flag), .svc_req(svc_req)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] v);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
        host_addr = a;
        #0.5;
        v = host_rdata;
    endtask

    function automatic logic exp_pin(input logic p, input int code);
        case (code)
            1: return 1'b1;
            2: return 1'b0;
            3: return ~p;
            default: return p;
        endcase
    endfunction

    logic [W-1:0] v;

    initial begin
        // R1 reset state
        repeat (3) tick();
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk($sformatf("R1 addr %0d", a), v, '0);
        end
        chk("R1 pin_out", W'(pin_out), '0);
        chk("R1 svc_req", W'(svc_req), '0);
        chk("R1 evt_flag", W'(evt_flag), '0);
        rst_n = 1'b1;
        tick();

        // R2 / R3 / R4 sweep over match value and distance
        begin
            logic [W-1:0] ms [4] = '{24'h000000, 24'hFFFFFF, 24'h7FFFFF, 24'h123456};
            logic [W-1:0] ds [9] = '{24'h0, 24'h1, 24'h2, 24'h64, 24'h7FFFFF,
                                     24'h800000, 24'h800001, 24'hFFFFFE, 24'hFFFFFF};
            for (int e = 0; e < 2; e++) begin
                for (int mi = 0; mi < 4; mi++) begin
                    for (int di = 0; di < 9; di++) begin
                        logic fire;
                        logic [W-1:0] other;
                        fire  = (e == 1) ? (ds[di] == 0) : (ds[di] < 24'h800000);
                        other = ms[mi] ^ 24'h5A5A5A;
                        wr(3'd0, (e == 1) ? 24'h2 : 24'h0);
                        wr(3'd5, 24'h3);
                        wr(3'd1, ms[mi]);
                        time_a = (ms[mi] + ds[di]) & MASK;
                        time_b = other;
                        tick();
                        rd(3'd5, v);
                        chk((e == 1) ? "R3 flag A" : "R2 flag A", W'(v[0]), W'(fire));
                        chk((e == 1) ? "R3 armed A" : "R2 armed A", W'(v[2]), W'(!fire));
                        if (fire) begin
                            rd(3'd3, v);
                            chk("R4 capture opposite base", v, other);
                        end
                    end
                end
            end
        end

        // R4 base select: compare time_b, capture time_a
        wr(3'd0, 24'h80);
        time_b = 24'd10;
        wr(3'd1, 24'd50);
        time_b = 24'd60; time_a = 24'h111111;
        tick();
        rd(3'd3, v);
        chk("R4 base select capture", v, 24'h111111);
        rd(3'd5, v);
        chk("R4 base select flag", W'(v[0]), 24'd1);

        // R5 pin actions, every code from both starting levels
        time_a = '0;
        for (int p = 0; p < 2; p++) begin
            for (int x = 0; x < 4; x++) begin
                wr(3'd0, W'((p == 1 ? 1 : 2) << 3));
                wr(3'd1, '0);
                tick();
                chk("R5 preset", W'(pin_out), W'(p));
                wr(3'd0, W'(x << 3));
                wr(3'd1, '0);
                tick();
                chk($sformatf("R5 code %0d from %0d", x, p), W'(pin_out), W'(exp_pin(1'(p), x)));
                chk("R10 out state", W'(pin_out_state), W'(exp_pin(1'(p), x)));
            end
        end

        // R6 single mode independence; A sets, B clears
        wr(3'd5, 24'h3);
        wr(3'd0, W'((1 << 3) | (2 << 5)));
        time_a = 24'd0;
        wr(3'd1, 24'd100);
        wr(3'd2, 24'd200);
        time_a = 24'd150;
        tick();
        chk("R6 only A fired", W'(evt_flag), 24'd1);
        chk("R6 pin high", W'(pin_out), 24'd1);
        chk("R11 svc on", W'(svc_req), 24'd1);
        time_a = 24'd250;
        tick();
        chk("R6 B fired", W'(evt_flag), 24'd3);
        chk("R6 pin low", W'(pin_out), 24'd0);
        // both in one cycle, both toggle: A then B returns level
        wr(3'd0, W'((3 << 3) | (3 << 5)));
        time_a = 24'd0;
        wr(3'd1, 24'd300);
        wr(3'd2, 24'd300);
        time_a = 24'd300;
        tick();
        chk("R5 double toggle order", W'(pin_out), 24'd0);
        chk("R6 both flags", W'(evt_flag), 24'd3);

        // R8 flags persist, W1C and rewrite clears
        repeat (4) tick();
        chk("R8 hold", W'(evt_flag), 24'd3);
        wr(3'd5, 24'h1);
        chk("R8 W1C A only", W'(evt_flag), 24'd2);
        time_a = 24'd0;
        wr(3'd2, 24'd900);
        chk("R8 rewrite clears B", W'(evt_flag), 24'd0);
        chk("R11 svc off", W'(svc_req), 24'd0);
        rd(3'd5, v);
        chk("R8 rewrite arms B", W'(v[3]), 24'd1);
        time_a = 24'd1000;
        tick();
        chk("R8 B fires after rearm", W'(evt_flag), 24'd2);

        // R7 double action: A sets high, B clears low
        wr(3'd5, 24'h3);
        wr(3'd0, W'(1 | (1 << 3) | (2 << 5)));
        time_a = 24'd500;
        time_b = 24'hABCDEF;
        wr(3'd2, 24'd10);
        wr(3'd1, 24'd1000);
        tick();
        chk("R7 B waits", W'(evt_flag), 24'd0);
        rd(3'd5, v);
        chk("R7 B not armed", W'(v[3]), 24'd0);
        time_a = 24'd1000;
        tick();
        chk("R7 A fired", W'(evt_flag), 24'd1);
        chk("R7 pin high", W'(pin_out), 24'd1);
        tick();
        chk("R7 B fired next", W'(evt_flag), 24'd3);
        chk("R7 pin low", W'(pin_out), 24'd0);
        rd(3'd4, v);
        chk("R7 capture B", v, 24'hABCDEF);

        // R9 edge capture, rising selected, equal-only so no match
        wr(3'd5, 24'h3);
        wr(3'd0, W'((1 << 9) | 2 | (1 << 3)));
        time_a = 24'd7;
        wr(3'd1, 24'h999);
        pin_in = 1'b1;
        rd(3'd5, v);
        chk("R10 level lags", W'(v[4]), 24'd0);
        tick();
        chk("R10 level seen", W'(pin_in_state), 24'd1);
        chk("R9 not yet", W'(evt_flag), 24'd0);
        tick();
        chk("R9 edge flag", W'(evt_flag), 24'd1);
        chk("R9 pin untouched", W'(pin_out), 24'd0);
        rd(3'd3, v);
        chk("R9 own base captured", v, 24'd7);
        wr(3'd1, 24'h999);
        pin_in = 1'b0;
        repeat (3) tick();
        chk("R9 falling ignored", W'(evt_flag), 24'd0);
        rd(3'd0, v);
        chk("R11 ctrl readback", v, W'((1 << 9) | 2 | (1 << 3)));

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule